// File: doc/BRIEF.md
# Sized Load/Store and Stack Access Unit

This unit performs the data-memory side of a 32-bit CPU's load, store and stack instructions. The core hands it one operation at a time: an operation code, the value of the data register and the value of the register holding the address or stack pointer. The unit issues a single request to a byte-addressed, little-endian memory. It then returns the load result, the updated stack pointer for push and pop, or a data-fault indication with the offending address.

Long (32-bit), word (16-bit) and byte transfers are supported. Narrow loads can be zero- or sign-extended, and narrow stores touch only the byte lanes they cover. Push writes at the current pointer and then moves it down by four. Pop moves the pointer up by four first and reads at the moved pointer. A misaligned access produces a fault and never reaches memory.

The memory port is a simple synchronous one. The request is held for one cycle, and the read data is valid in the cycle after it.

Top module: `stack_mem_unit`

## Requirements
- R1: While and directly after reset, `busy`, `done`, `memReq`, `fault`, `loadValid` and `baseWrite` are all low.
- R2: Operation codes: 0 long load, 1 long store, 2 word load zero-extended, 3 word store, 4 byte load zero-extended, 5 byte store, 6 word load sign-extended, 7 byte load sign-extended, 8 push, 9 pop. A `start` that is sampled while `busy` is low is accepted. An aligned access then drives `memReq` for exactly the next cycle, and `done` pulses for one cycle in the cycle after that. A faulting access raises `done` in the first cycle after acceptance.
- R3: A long load returns the 32-bit memory word at the address. A long store writes all of `dataIn` with `memBe` = 4'b1111.
- R4: A word store enables lanes 4'b0011 shifted left by address bits [1:0], and a byte store enables 4'b0001 shifted the same way. Only the low 16 or 8 bits of `dataIn` are written, with address byte 0 in bits [7:0] of a memory word (little-endian). All other bytes keep their value.
- R5: Word and byte zero-extending loads (codes 2 and 4) return the addressed halfword or byte with the upper bits cleared.
- R6: Word and byte sign-extending loads (codes 6 and 7) copy bit 15 or bit 7 of the loaded value into all upper bits.
- R7: Push writes `dataIn` as a long word at `baseIn`. At `done` it reports `baseWrite` high with `baseOut` = `baseIn` - 4.
- R8: Pop reads the long word at `baseIn` + 4 and returns it as the load result. At `done` it reports `baseWrite` high with `baseOut` = `baseIn` + 4.
- R9: A word access at an odd address, or a long, push or pop access whose effective address is not a multiple of 4, is a fault. At `done` it gives `fault` high, `faultVector` = 2 and `faultAddr` = the effective address. It issues no memory request, changes no memory, and keeps `loadValid` and `baseWrite` low.
- R10: Byte accesses never fault, at any of the four byte offsets.
- R11: A `start` that arrives while `busy` is high is ignored. No operation results from it and memory is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation request, sampled when idle |
| opCode | input | 4 | Operation code (see R2) |
| dataIn | input | 32 | Data register value (store source) |
| baseIn | input | 32 | Address / stack pointer register value |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory request strobe |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the request |
| memWdata | output | 32 | Write data, replicated over lanes |
| memBe | output | 4 | Byte-lane enables |
| memRdata | input | 32 | Read data, valid the cycle after the request |
| done | output | 1 | Completion pulse |
| loadValid | output | 1 | `loadResult` carries a value |
| loadResult | output | 32 | Extended load result |
| baseWrite | output | 1 | `baseOut` must be written back |
| baseOut | output | 32 | Updated stack pointer |
| fault | output | 1 | Data fault at completion |
| faultVector | output | 5 | Exception vector number on fault |
| faultAddr | output | 32 | Faulting effective address |

## Verification
The assertions assume that memory answers every read in the cycle after the request and never stalls. They also assume that `start` may arrive in any cycle, busy or not. The stimulus keeps every address inside a 64-byte window modelled by the bench, which answers with this fixed one-cycle latency. To exercise the ignore rule, the stimulus deliberately raises `start` while an operation is still in flight.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [3:0] {
    OP_LD_L  = 4'd0,
    OP_ST_L  = 4'd1,
    OP_LD_WZ = 4'd2,
    OP_ST_W  = 4'd3,
    OP_LD_BZ = 4'd4,
    OP_ST_B  = 4'd5,
    OP_LD_WS = 4'd6,
    OP_LD_BS = 4'd7,
    OP_PUSH  = 4'd8,
    OP_POP   = 4'd9
  } memOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } accSize_e;

  typedef struct packed {
    logic capture;
    logic issue;
    logic finish;
  } ctrlStrobe_t;

  typedef struct packed {
    accSize_e size;
    logic     signExt;
    logic     isWrite;
    logic     isLoad;
    logic     isPush;
    logic     isPop;
  } opAttr_t;

  function automatic opAttr_t decodeOp(input logic [3:0] code);
    opAttr_t a;
    a = '{size: SZ_LONG, signExt: 1'b0, isWrite: 1'b0, isLoad: 1'b1,
          isPush: 1'b0, isPop: 1'b0};
    case (code)
      OP_ST_L:  begin a.isWrite = 1'b1; a.isLoad = 1'b0; end
      OP_LD_WZ: a.size = SZ_WORD;
      OP_ST_W:  begin a.size = SZ_WORD; a.isWrite = 1'b1; a.isLoad = 1'b0; end
      OP_LD_BZ: a.size = SZ_BYTE;
      OP_ST_B:  begin a.size = SZ_BYTE; a.isWrite = 1'b1; a.isLoad = 1'b0; end
      OP_LD_WS: begin a.size = SZ_WORD; a.signExt = 1'b1; end
      OP_LD_BS: begin a.size = SZ_BYTE; a.signExt = 1'b1; end
      OP_PUSH:  begin a.isWrite = 1'b1; a.isLoad = 1'b0; a.isPush = 1'b1; end
      OP_POP:   a.isPop = 1'b1;
      default:  ;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/smu_ctrl.sv
module smu_ctrl
  import smu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        misaligned,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FIN} ctrlState_e;

  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stateNext      = misaligned ? ST_FIN : ST_REQ;
      end
      ST_REQ: begin
        strobe.issue = 1'b1;
        stateNext    = ST_FIN;
      end
      ST_FIN: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/smu_dpath.sv
module smu_dpath
  import smu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STEP      = 4,
  parameter int VEC_W     = 5,
  parameter int FAULT_VEC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [ADDR_W-1:0]   baseIn,
  output logic                misaligned,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [LANES-1:0]    memBe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                done,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult,
  output logic                baseWrite,
  output logic [ADDR_W-1:0]   baseOut,
  output logic                fault,
  output logic [VEC_W-1:0]    faultVector,
  output logic [ADDR_W-1:0]   faultAddr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  localparam logic [VEC_W-1:0]  VEC_V  = VEC_W'(FAULT_VEC);

  opAttr_t             attrIn, attrR;
  logic [ADDR_W-1:0]   effAddr, nextBase;
  logic [ADDR_W-1:0]   accAddr, baseR;
  logic [DATA_W-1:0]   dataR;
  logic                faultR;
  logic [1:0]          laneIdx;
  logic [DATA_W-1:0]   shifted, extVal;

  // Decode and address arithmetic on the incoming operation
  always_comb begin
    attrIn   = decodeOp(opCode);
    effAddr  = attrIn.isPop ? baseIn + STEP_V : baseIn;
    nextBase = attrIn.isPush ? baseIn - STEP_V
             : attrIn.isPop  ? baseIn + STEP_V : baseIn;
    case (attrIn.size)
      SZ_LONG: misaligned = (effAddr[1:0] != 2'b00);
      SZ_WORD: misaligned = effAddr[0];
      default: misaligned = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      attrR   <= '{size: SZ_LONG, signExt: 1'b0, isWrite: 1'b0, isLoad: 1'b0,
                   isPush: 1'b0, isPop: 1'b0};
      accAddr <= '0;
      baseR   <= '0;
      dataR   <= '0;
      faultR  <= 1'b0;
    end else if (strobe.capture) begin
      attrR   <= attrIn;
      accAddr <= effAddr;
      baseR   <= nextBase;
      dataR   <= dataIn;
      faultR  <= misaligned;
    end
  end

  assign laneIdx = accAddr[1:0];

  // Request side: lane enables and lane-replicated write data
  always_comb begin
    case (attrR.size)
      SZ_BYTE: begin
        memBe    = LANES'(1) << laneIdx;
        memWdata = {LANES{dataR[7:0]}};
      end
      SZ_WORD: begin
        memBe    = LANES'(3) << laneIdx;
        memWdata = {(LANES/2){dataR[15:0]}};
      end
      default: begin
        memBe    = '1;
        memWdata = dataR;
      end
    endcase
  end

  assign memReq   = strobe.issue;
  assign memWrite = strobe.issue & attrR.isWrite;
  assign memAddr  = accAddr;

  // Response side: lane select and extension
  always_comb begin
    shifted = memRdata >> {laneIdx, 3'b000};
    case (attrR.size)
      SZ_BYTE: extVal = {{(DATA_W-8){attrR.signExt & shifted[7]}}, shifted[7:0]};
      SZ_WORD: extVal = {{(DATA_W-16){attrR.signExt & shifted[15]}}, shifted[15:0]};
      default: extVal = memRdata;
    endcase
  end

  assign done        = strobe.finish;
  assign fault       = strobe.finish & faultR;
  assign faultVector = fault ? VEC_V : '0;
  assign faultAddr   = fault ? accAddr : '0;
  assign loadValid   = strobe.finish & attrR.isLoad & ~faultR;
  assign loadResult  = loadValid ? extVal : '0;
  assign baseWrite   = strobe.finish & (attrR.isPush | attrR.isPop) & ~faultR;
  assign baseOut     = baseR;
endmodule

// File: rtl/stack_mem_unit.sv
module stack_mem_unit
  import smu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STEP      = 4,
  parameter int VEC_W     = 5,
  parameter int FAULT_VEC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [ADDR_W-1:0]   baseIn,
  output logic                busy,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [LANES-1:0]    memBe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                done,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult,
  output logic                baseWrite,
  output logic [ADDR_W-1:0]   baseOut,
  output logic                fault,
  output logic [VEC_W-1:0]    faultVector,
  output logic [ADDR_W-1:0]   faultAddr
);
  ctrlStrobe_t strobe;
  logic        misaligned;

  smu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .misaligned(misaligned),
    .strobe(strobe), .busy(busy)
  );

  smu_dpath #(.ADDR_W(ADDR_W), .STEP(STEP), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .opCode(opCode), .dataIn(dataIn),
    .baseIn(baseIn), .misaligned(misaligned), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memRdata(memRdata),
    .done(done), .loadValid(loadValid), .loadResult(loadResult),
    .baseWrite(baseWrite), .baseOut(baseOut), .fault(fault),
    .faultVector(faultVector), .faultAddr(faultAddr)
  );
endmodule

// File: rtl/smu_chk.sv
module smu_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       memReq,
  input logic [1:0] memAddrLo,
  input logic [3:0] memBe,
  input logic       done,
  input logic       fault,
  input logic       loadValid,
  input logic       baseWrite
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_req_then_done_R2: assert property (@(posedge clk) disable iff (rst)
    memReq |=> (done && !memReq));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_lane_shape_R4: assert property (@(posedge clk) disable iff (rst)
    memReq |-> ($countones(memBe) == 1 || memBe == 4'b0011 ||
                memBe == 4'b1100 || memBe == 4'b1111));

  assert_long_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (memReq && memBe == 4'b1111) |-> (memAddrLo == 2'b00));

  assert_fault_no_req_R9: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !$past(memReq));

  assert_fault_no_side_R9: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!baseWrite && !loadValid));
endmodule

bind stack_mem_unit smu_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .memReq(memReq),
  .memAddrLo(memAddr[1:0]), .memBe(memBe), .done(done), .fault(fault),
  .loadValid(loadValid), .baseWrite(baseWrite)
);

// File: tb/sim_stack_mem_unit.sv
`timescale 1ns/1ps
module sim_stack_mem_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] dataIn = '0, baseIn = '0;
  logic        busy, memReq, memWrite, done, loadValid, baseWrite, fault;
  logic [31:0] memAddr, memWdata, loadResult, baseOut, faultAddr;
  logic [31:0] memRdata = '0;
  logic [3:0]  memBe;
  logic [4:0]  faultVector;

  always #2.5 clk = ~clk;

  stack_mem_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opCode(opCode), .dataIn(dataIn),
    .baseIn(baseIn), .busy(busy), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memRdata(memRdata),
    .done(done), .loadValid(loadValid), .loadResult(loadResult),
    .baseWrite(baseWrite), .baseOut(baseOut), .fault(fault),
    .faultVector(faultVector), .faultAddr(faultAddr)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];

  function automatic logic [31:0] initWord(input int i);
    return 32'h0F1E2D3C ^ (i * 32'h01010101);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= initWord(i);
    end else if (memReq) begin
      if (memWrite) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[5:2]][8*b +: 8] <= memWdata[8*b +: 8];
      end else begin
        memRdata <= mem[memAddr[5:2]];
      end
    end
  end

  typedef struct {
    string       tag;
    int          lat;
    int          issueCyc;
    logic        eFault;
    logic [31:0] eFaultAddr;
    logic        eLoad;
    logic [31:0] eResult;
    logic        eBase;
    logic [31:0] eBaseVal;
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare at each completion
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected done", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(cyc - e.issueCyc == e.lat, {e.tag, " R2 latency"},
              32'(cyc - e.issueCyc), 32'(e.lat));
        check(fault == e.eFault, {e.tag, " fault"}, 32'(fault), 32'(e.eFault));
        if (e.eFault) begin
          check(faultAddr == e.eFaultAddr, {e.tag, " R9 faultAddr"}, faultAddr, e.eFaultAddr);
          check(faultVector == 5'd2, {e.tag, " R9 vector"}, 32'(faultVector), 32'd2);
        end
        check(loadValid == e.eLoad, {e.tag, " loadValid"}, 32'(loadValid), 32'(e.eLoad));
        if (e.eLoad)
          check(loadResult == e.eResult, {e.tag, " result"}, loadResult, e.eResult);
        check(baseWrite == e.eBase, {e.tag, " baseWrite"}, 32'(baseWrite), 32'(e.eBase));
        if (e.eBase)
          check(baseOut == e.eBaseVal, {e.tag, " baseOut"}, baseOut, e.eBaseVal);
      end
    end
  end

  // Bench-side model of the expected outcome, from the requirements
  function automatic expItem_t predict(input logic [3:0] op, input logic [31:0] d,
                                       input logic [31:0] base, input string tag);
    expItem_t e;
    logic [31:0] ea, w, sh;
    int sz;  // 1, 2 or 4 bytes
    bit ld, sgn;
    e.tag = tag; e.eFault = 0; e.eFaultAddr = 0; e.eLoad = 0; e.eResult = 0;
    e.eBase = 0; e.eBaseVal = 0; e.issueCyc = 0;
    sz  = (op == 4 || op == 5 || op == 7) ? 1 : (op == 2 || op == 3 || op == 6) ? 2 : 4;
    ld  = (op == 0 || op == 2 || op == 4 || op == 6 || op == 7 || op == 9);
    sgn = (op == 6 || op == 7);
    ea  = (op == 9) ? base + 4 : base;
    if ((sz == 4 && ea[1:0] != 0) || (sz == 2 && ea[0])) begin
      e.eFault = 1; e.eFaultAddr = ea; e.lat = 1;
      return e;
    end
    e.lat = 2;
    if (ld) begin
      w  = shadow[ea[5:2]];
      sh = w >> (8 * ea[1:0]);
      if (sz == 1)      e.eResult = sgn ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
      else if (sz == 2) e.eResult = sgn ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]};
      else              e.eResult = w;
      e.eLoad = 1;
    end else begin
      for (int b = 0; b < sz; b++)
        shadow[ea[5:2]][8*(ea[1:0] + b) +: 8] = d[8*b +: 8];
    end
    if (op == 8) begin e.eBase = 1; e.eBaseVal = base - 4; end
    if (op == 9) begin e.eBase = 1; e.eBaseVal = base + 4; end
    return e;
  endfunction

  // Driver; with intrude set, a long store to intrAddr is attempted while busy
  task automatic doOp(input logic [3:0] op, input logic [31:0] d, input logic [31:0] base,
                      input string tag, input bit intrude = 0,
                      input logic [31:0] intrAddr = 0);
    expItem_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = predict(op, d, base, tag);
    e.issueCyc = cyc;
    expQ.push_back(e);
    opCode = op; dataIn = d; baseIn = base; start = 1'b1;
    @(negedge clk);
    if (intrude) begin
      opCode = 4'd1; dataIn = 32'hDEADBEEF; baseIn = intrAddr;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = initWord(i);
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset and right after release
    check(!busy && !done && !memReq && !fault && !loadValid && !baseWrite,
          "R1 idle in reset", {26'd0, busy, done, memReq, fault, loadValid, baseWrite}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !memReq && !fault && !loadValid && !baseWrite,
          "R1 idle after reset", {26'd0, busy, done, memReq, fault, loadValid, baseWrite}, 0);

    doOp(4'd1, 32'h89ABCDEF, 32'h10, "R3 long store");
    doOp(4'd0, 32'h0, 32'h10, "R3 long load");
    doOp(4'd5, 32'h7777775A, 32'h13, "R4 byte store lane3");
    doOp(4'd0, 32'h0, 32'h10, "R4 readback after byte");
    doOp(4'd3, 32'h99991234, 32'h12, "R4 word store upper");
    doOp(4'd0, 32'h0, 32'h10, "R4 readback after word");
    doOp(4'd3, 32'h0000F00D, 32'h18, "R4 word store lower");
    doOp(4'd0, 32'h0, 32'h18, "R4 readback lower word");
    doOp(4'd4, 32'h0, 32'h13, "R5 byte zero ext");
    doOp(4'd2, 32'h0, 32'h10, "R5 word zero ext");
    doOp(4'd7, 32'h0, 32'h11, "R6 byte sign ext neg");
    doOp(4'd7, 32'h0, 32'h13, "R6 byte sign ext pos");
    doOp(4'd6, 32'h0, 32'h10, "R6 word sign ext neg");
    doOp(4'd6, 32'h0, 32'h12, "R6 word sign ext pos");
    doOp(4'd2, 32'h0, 32'h18, "R5 word zero ext high bit");
    doOp(4'd8, 32'hCAFEF00D, 32'h20, "R7 push");
    doOp(4'd0, 32'h0, 32'h20, "R7 push readback");
    doOp(4'd8, 32'h13572468, 32'h1C, "R7 second push");
    doOp(4'd9, 32'h0, 32'h18, "R8 pop first");
    doOp(4'd9, 32'h0, 32'h1C, "R8 pop second");
    doOp(4'd0, 32'h0, 32'h22, "R9 misaligned long load");
    doOp(4'd3, 32'h0000ABCD, 32'h15, "R9 odd word store");
    doOp(4'd1, 32'h11112222, 32'h16, "R9 misaligned long store");
    doOp(4'd0, 32'h0, 32'h14, "R9 no write readback");
    doOp(4'd8, 32'h55555555, 32'h26, "R9 push misaligned");
    doOp(4'd9, 32'h0, 32'h1E, "R9 pop misaligned");
    doOp(4'd6, 32'h0, 32'h2B, "R9 odd word load");
    doOp(4'd2, 32'h0, 32'h2A, "R9 word at offset 2 ok");
    for (int k = 0; k < 4; k++)
      doOp(4'd5, 32'hA0 + k, 32'h30 + k, $sformatf("R10 byte store off%0d", k));
    doOp(4'd0, 32'h0, 32'h30, "R10 byte readback");
    for (int k = 0; k < 4; k++)
      doOp(4'd7, 32'h0, 32'h30 + k, $sformatf("R10 byte load off%0d", k));
    doOp(4'd0, 32'h0, 32'h08, "R11 load with intruder", 1'b1, 32'h04);
    doOp(4'd0, 32'h0, 32'h04, "R11 intruder ignored");

    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 all completions seen", 32'(expQ.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule